// File: doc/BRIEF.md
# Timer Compare Channel

This block is a single compare channel of a general-purpose timer. It watches a free-running counter value supplied from outside, compares it with a stored compare value, and drives a one-bit reference level. A three-bit mode input chooses how that level reacts. It can stay frozen, go high or low on a match, toggle on a match, be forced to a fixed level, or form a pulse-width waveform in either polarity.

The compare value is loaded through a single-cycle write strobe. Writes can apply at once, or they can wait in a shadow register until the next update-event pulse. A fast path, when enabled, turns the rising edge of a trigger input into a compare match. A direction input can take the channel out of output service; the reference level then stays put. A fourth mode bit marks a reserved setting, and while it is set the reference level is also held.

Top module: `tcmp_channel`

## Requirements
- R1: After reset `ref_o` is 0 and `cmp_o` is 0.
- R2: With `mode_i` = 3'd0 (frozen), `ref_o` keeps its level whether or not the counter equals the compare value.
- R3: With `mode_i` = 3'd1, a clock edge at which `cnt_i` equals `cmp_o` makes `ref_o` 1. With `mode_i` = 3'd2, such an edge makes it 0. At edges without a match, `ref_o` is unchanged.
- R4: With `mode_i` = 3'd3, `ref_o` inverts at every clock edge where `cnt_i` equals `cmp_o`, and holds at other edges.
- R5: With `mode_i` = 3'd4, `ref_o` becomes 0 after the next edge. With `mode_i` = 3'd5, it becomes 1. The comparison plays no part in either mode.
- R6: With `mode_i` = 3'd6, `ref_o` after an edge is 1 exactly when `cnt_i` < `cmp_o` at that edge. With `mode_i` = 3'd7, it is the inverse.
- R7: With `preload_en_i` = 0, a write (`wr_en_i` = 1) places `wr_data_i` in `cmp_o` after that edge.
- R8: With `preload_en_i` = 1, a write leaves `cmp_o` unchanged and goes to a shadow register. An edge with `update_i` = 1 copies the shadow into `cmp_o`. If a write and an update fall on the same edge, `cmp_o` takes the shadow value held before that write.
- R9: With `fast_en_i` = 1, a rising edge of `trig_i` counts as a match in modes 1, 2 and 3, once per rising edge. A trigger held high does not match again. With `fast_en_i` = 0, `trig_i` has no effect.
- R10: While `dir_in_i` = 1 (channel in input use), `ref_o` holds its level in every mode, including the forced modes.
- R11: While `mode_ext_i` = 1 (reserved mode), `ref_o` holds its level whatever `mode_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current timer counter value |
| wr_en_i | input | 1 | Compare value write strobe |
| wr_data_i | input | CNT_W | Compare value to write |
| mode_i | input | 3 | Reference behaviour select |
| mode_ext_i | input | 1 | Fourth mode bit; 1 selects a reserved mode (hold) |
| preload_en_i | input | 1 | 1 routes writes through the shadow register |
| fast_en_i | input | 1 | 1 lets a trigger rising edge act as a match |
| dir_in_i | input | 1 | 0 output use, 1 input use (reference held) |
| trig_i | input | 1 | Trigger input |
| update_i | input | 1 | Update-event pulse |
| ref_o | output | 1 | Reference output level |
| cmp_o | output | CNT_W | Active compare value |

## Verification
The counter is placed below, on and above the compare value, and the output is checked in each mode. Set, clear and toggle modes must react only on the equal value. The two PWM modes separate strict less-than from less-or-equal at the boundary. Frozen, forced, input-use and reserved settings are tried with the output both high and low, and with matches present, so a hold can be told apart from a forced level. Write order is checked against the update pulse, including both arriving on the same edge. Trigger patterns separate a rising edge from a held level, with and without the fast path.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [2:0] {
    MD_FROZEN = 3'd0,
    MD_SET    = 3'd1,
    MD_CLEAR  = 3'd2,
    MD_TOGGLE = 3'd3,
    MD_LOW    = 3'd4,
    MD_HIGH   = 3'd5,
    MD_PWM_A  = 3'd6,
    MD_PWM_B  = 3'd7
  } tcmp_mode_e;

  // Next reference level for one mode; hit = match, below = counter < compare.
  function automatic logic tcmp_next_ref(tcmp_mode_e m, logic cur, logic hit, logic below);
    logic nxt;
    case (m)
      MD_FROZEN: nxt = cur;
      MD_SET:    nxt = hit ? 1'b1 : cur;
      MD_CLEAR:  nxt = hit ? 1'b0 : cur;
      MD_TOGGLE: nxt = hit ? ~cur : cur;
      MD_LOW:    nxt = 1'b0;
      MD_HIGH:   nxt = 1'b1;
      MD_PWM_A:  nxt = below;
      MD_PWM_B:  nxt = ~below;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tcmp_cmp_reg.sv
module tcmp_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else if (preload_en_i) begin
      if (wr_en_i)  shadow_q <= wr_data_i;
      if (update_i) active_q <= shadow_q;
    end else if (wr_en_i) begin
      shadow_q <= wr_data_i;
      active_q <= wr_data_i;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/tcmp_trig_edge.sv
module tcmp_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/tcmp_ref_gen.sv
module tcmp_ref_gen
  import tcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       hold_i,
  input  logic       hit_i,
  input  logic       below_i,
  output logic       ref_o
);
  logic ref_q;
  logic ref_d;

  always_comb begin
    if (hold_i) ref_d = ref_q;
    else        ref_d = tcmp_next_ref(tcmp_mode_e'(mode_i), ref_q, hit_i, below_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       mode_i,
  input  logic             mode_ext_i,
  input  logic             preload_en_i,
  input  logic             fast_en_i,
  input  logic             dir_in_i,
  input  logic             trig_i,
  input  logic             update_i,
  output logic             ref_o,
  output logic [CNT_W-1:0] cmp_o
);
  logic [CNT_W-1:0] active_w;
  logic             rise_w;
  logic             equal_w;
  logic             below_w;
  logic             hit_w;
  logic             hold_w;

  tcmp_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .preload_en_i (preload_en_i),
    .update_i     (update_i),
    .active_o     (active_w)
  );

  tcmp_trig_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .rise_o (rise_w)
  );

  assign equal_w = (cnt_i == active_w);
  assign below_w = (cnt_i < active_w);
  assign hit_w   = equal_w | (fast_en_i & rise_w);
  assign hold_w  = dir_in_i | mode_ext_i;

  tcmp_ref_gen u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .hold_i  (hold_w),
    .hit_i   (hit_w),
    .below_i (below_w),
    .ref_o   (ref_o)
  );

  assign cmp_o = active_w;
endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [2:0]       mode_i,
  input logic             mode_ext_i,
  input logic             preload_en_i,
  input logic             dir_in_i,
  input logic             update_i,
  input logic             hit_w,
  input logic             ref_o,
  input logic [CNT_W-1:0] cmp_o
);
  logic live;
  assign live = !dir_in_i && !mode_ext_i;

  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_i == 3'd0) |=> $stable(ref_o));

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_i == 3'd3 && hit_w) |=> (ref_o != $past(ref_o)));

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_i == 3'd4) |=> !ref_o);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_i == 3'd5) |=> ref_o);

  p_pwm_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_i == 3'd6) |=> (ref_o == $past(cnt_i < cmp_o)));

  p_direct_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !preload_en_i) |=> (cmp_o == $past(wr_data_i)));

  p_preload_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en_i && !update_i) |=> $stable(cmp_o));

  p_input_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in_i |=> $stable(ref_o));

  p_reserved_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext_i |=> $stable(ref_o));
endmodule

bind tcmp_channel tcmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_i        (cnt_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .mode_i       (mode_i),
  .mode_ext_i   (mode_ext_i),
  .preload_en_i (preload_en_i),
  .dir_in_i     (dir_in_i),
  .update_i     (update_i),
  .hit_w        (hit_w),
  .ref_o        (ref_o),
  .cmp_o        (cmp_o)
);

// File: tb/tcmp_channel_tb_top.sv
module tcmp_channel_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             wr_en_i = 1'b0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic [2:0]       mode_i = 3'd0;
  logic             mode_ext_i = 1'b0;
  logic             preload_en_i = 1'b0;
  logic             fast_en_i = 1'b0;
  logic             dir_in_i = 1'b0;
  logic             trig_i = 1'b0;
  logic             update_i = 1'b0;
  logic             ref_o;
  logic [CNT_W-1:0] cmp_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic exp_ref;

  always #10 clk = ~clk;

  tcmp_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .mode_i(mode_i), .mode_ext_i(mode_ext_i),
    .preload_en_i(preload_en_i), .fast_en_i(fast_en_i), .dir_in_i(dir_in_i),
    .trig_i(trig_i), .update_i(update_i), .ref_o(ref_o), .cmp_o(cmp_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_ref(logic exp, string req);
    checks++;
    if (ref_o !== exp) begin
      failures++;
      $display("FAIL %s ref_o actual=%0b expected=%0b", req, ref_o, exp);
    end
  endtask

  task automatic chk_cmp(logic [CNT_W-1:0] exp, string req);
    checks++;
    if (cmp_o !== exp) begin
      failures++;
      $display("FAIL %s cmp_o actual=%0d expected=%0d", req, cmp_o, exp);
    end
  endtask

  // one edge in the given mode with the given counter
  task automatic step(logic [2:0] m, logic [CNT_W-1:0] c);
    mode_i = m;
    cnt_i  = c;
    tick();
  endtask

  task automatic t_reset();
    chk_ref(1'b0, "R1");
    chk_cmp('0, "R1");
  endtask

  task automatic t_direct_write();
    wr_en_i = 1'b1; wr_data_i = 16'd10;
    tick();
    wr_en_i = 1'b0;
    chk_cmp(16'd10, "R7");
  endtask

  task automatic t_set_clear();
    step(3'd1, 16'd5);  chk_ref(1'b0, "R3");
    step(3'd1, 16'd10); chk_ref(1'b1, "R3");
    step(3'd1, 16'd11); chk_ref(1'b1, "R3");
    step(3'd2, 16'd11); chk_ref(1'b1, "R3");
    step(3'd2, 16'd10); chk_ref(1'b0, "R3");
  endtask

  task automatic t_frozen();
    step(3'd0, 16'd10); chk_ref(1'b0, "R2");
    step(3'd1, 16'd10); chk_ref(1'b1, "R2");
    step(3'd0, 16'd10); chk_ref(1'b1, "R2");
    step(3'd0, 16'd3);  chk_ref(1'b1, "R2");
  endtask

  task automatic t_toggle();
    exp_ref = ref_o;
    step(3'd3, 16'd10); exp_ref = ~exp_ref; chk_ref(exp_ref, "R4");
    step(3'd3, 16'd10); exp_ref = ~exp_ref; chk_ref(exp_ref, "R4");
    step(3'd3, 16'd4);  chk_ref(exp_ref, "R4");
    step(3'd3, 16'd10); exp_ref = ~exp_ref; chk_ref(exp_ref, "R4");
  endtask

  task automatic t_force();
    step(3'd4, 16'd10); chk_ref(1'b0, "R5");
    step(3'd5, 16'd3);  chk_ref(1'b1, "R5");
    step(3'd5, 16'd10); chk_ref(1'b1, "R5");
    step(3'd4, 16'd3);  chk_ref(1'b0, "R5");
  endtask

  task automatic t_pwm();
    step(3'd6, 16'd0);  chk_ref(1'b1, "R6");
    step(3'd6, 16'd9);  chk_ref(1'b1, "R6");
    step(3'd6, 16'd10); chk_ref(1'b0, "R6");
    step(3'd6, 16'd11); chk_ref(1'b0, "R6");
    step(3'd7, 16'd9);  chk_ref(1'b0, "R6");
    step(3'd7, 16'd10); chk_ref(1'b1, "R6");
  endtask

  task automatic t_preload();
    mode_i = 3'd0; preload_en_i = 1'b1;
    wr_en_i = 1'b1; wr_data_i = 16'd20;
    tick();
    wr_en_i = 1'b0;
    chk_cmp(16'd10, "R8");
    tick();
    chk_cmp(16'd10, "R8");
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
    chk_cmp(16'd20, "R8");
    wr_en_i = 1'b1; wr_data_i = 16'd30; update_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
    chk_cmp(16'd20, "R8");
    tick();
    update_i = 1'b0;
    chk_cmp(16'd30, "R8");
    preload_en_i = 1'b0;
  endtask

  task automatic t_fast();
    step(3'd4, 16'd0); chk_ref(1'b0, "R9");
    fast_en_i = 1'b0; trig_i = 1'b1;
    step(3'd1, 16'd0); chk_ref(1'b0, "R9");
    trig_i = 1'b0; fast_en_i = 1'b1;
    step(3'd1, 16'd0); chk_ref(1'b0, "R9");
    trig_i = 1'b1;
    step(3'd1, 16'd0); chk_ref(1'b1, "R9");
    step(3'd2, 16'd0); chk_ref(1'b1, "R9");
    trig_i = 1'b0;
    step(3'd2, 16'd0); chk_ref(1'b1, "R9");
    trig_i = 1'b1;
    step(3'd2, 16'd0); chk_ref(1'b0, "R9");
    trig_i = 1'b0; fast_en_i = 1'b0;
  endtask

  task automatic t_input();
    step(3'd5, 16'd0); chk_ref(1'b1, "R10");
    dir_in_i = 1'b1;
    step(3'd4, 16'd0);  chk_ref(1'b1, "R10");
    step(3'd3, 16'd30); chk_ref(1'b1, "R10");
    step(3'd6, 16'd40); chk_ref(1'b1, "R10");
    dir_in_i = 1'b0;
    step(3'd4, 16'd0); chk_ref(1'b0, "R10");
  endtask

  task automatic t_reserved();
    step(3'd5, 16'd0); chk_ref(1'b1, "R11");
    mode_ext_i = 1'b1;
    step(3'd4, 16'd0);  chk_ref(1'b1, "R11");
    step(3'd2, 16'd30); chk_ref(1'b1, "R11");
    mode_ext_i = 1'b0;
    step(3'd4, 16'd0); chk_ref(1'b0, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_direct_write();
    t_set_clear();
    t_frozen();
    t_toggle();
    t_force();
    t_pwm();
    t_preload();
    t_fast();
    t_input();
    t_reserved();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule